// File: doc/BRIEF.md
# Dual Parallel Quad-SPI Bit Interleaver

This block sits between a byte-oriented flash command engine and two identical quad-SPI flash devices. The two devices share one chip-select and one serial clock, and each device has its own 4-bit data bus. When the pair is enabled, the block sends every command and address nibble to both buses at once. In the data phase it stripes each host byte across the two devices by bit parity, so one serial clock moves a whole byte. Nibbles coming back from the devices are merged into bytes in the same way.

The block also handles the host view of the pair. A host byte address becomes a device address shifted right by one. Bank selection and read clipping use a bank twice the device bank. Page, sector, block, bank and capacity sizes are reported as base-2 logarithms, each one larger than a single device's. Transfers with an odd start address or an odd length cannot be expressed once the address is halved, so they are rejected. Status bytes from the two devices are kept apart, and busy is their OR. When either configuration bit is clear, the block acts as a plain single-device path.

Top module: `qstripe_top`

## Requirements
- R1: Pair mode is on only when both `cfg_sep_bus` and `cfg_two_mem` are 1. With either bit at 0, every output follows the single-device rules in R5, R6, R7, R8, R10 and R11.
- R2: In pair mode with `tx_data_phase`=0, both `io_lo_out` and `io_hi_out` carry `tx_nib` one cycle later, and `io_oe_hi` is 1.
- R3: In pair mode with `tx_data_phase`=1, one cycle later `io_lo_out[3:0]` = {`tx_byte[6]`,`tx_byte[4]`,`tx_byte[2]`,`tx_byte[0]`} and `io_hi_out[3:0]` = {`tx_byte[7]`,`tx_byte[5]`,`tx_byte[3]`,`tx_byte[1]`}.
- R4: In pair mode, one cycle later `rx_byte[2k]` = `rx_lo[k]` and `rx_byte[2k+1]` = `rx_hi[k]`, for k = 0..3.
- R5: In single mode, one cycle later `io_lo_out` = `tx_nib`, `io_hi_out` = 0, `io_oe_hi` = 0 and `rx_byte` = {4'h0, `rx_lo`}. This holds whatever `tx_data_phase` is.
- R6: For an accepted request, `acc_dev_addr` is `req_addr` shifted right by one in pair mode, and `req_addr` unchanged in single mode.
- R7: In pair mode, a request with `req_addr[0]`=1 or `req_len[0]`=1 gives `acc_err`=1 and `acc_len`=0. Single mode never sets `acc_err`.
- R8: `acc_bank` is `req_addr` shifted right by BANK_LOG2+1 in pair mode (32 MB banks with the default parameters) and by BANK_LOG2 in single mode.
- R9: For a request that is not rejected, `acc_len` is the smaller of `req_len` and the number of bytes from `req_addr` to the end of its bank, using the bank size from R8.
- R10: On `sts_valid`, one cycle later `sts_lo_q` = `sts_lo`. `sts_hi_q` = `sts_hi` in pair mode and 0 in single mode. `busy` = `sts_lo[0]` OR (pair mode AND `sts_hi[0]`). Bit 0 is the write-in-progress flag. Without `sts_valid`, all three outputs hold their values.
- R11: The geometry outputs, combinational from the configuration bits, are DEV_PAGE_LOG2, SECT_LOG2, BLK_LOG2, BANK_LOG2 and DEV_CAP_LOG2, each plus 1 in pair mode. The defaults are 8, 12, 15, 24 and 24.
- R12: `acc_valid` is 1 in exactly the cycle after a cycle with `req_valid`=1. The fields `acc_err`, `acc_dev_addr`, `acc_bank` and `acc_len` change only on such a cycle. All registered outputs are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sep_bus | input | 1 | Separate-bus enable |
| cfg_two_mem | input | 1 | Two-device enable |
| req_valid | input | 1 | Host transfer request strobe |
| req_addr | input | AW | Host byte address |
| req_len | input | AW | Host byte length |
| acc_valid | output | 1 | Request result strobe |
| acc_err | output | 1 | Request rejected (odd address or length) |
| acc_dev_addr | output | AW | Per-device address |
| acc_bank | output | AW-BANK_LOG2 | Bank select value |
| acc_len | output | AW | Length clipped to the bank end |
| tx_data_phase | input | 1 | 1 in the data phase, 0 in command or address phase |
| tx_nib | input | 4 | Command/address nibble, or the single-mode data nibble |
| tx_byte | input | 8 | Data byte for the pair data phase |
| io_lo_out | output | 4 | Lower device bus drive |
| io_hi_out | output | 4 | Upper device bus drive |
| io_oe_hi | output | 1 | Upper bus in use |
| rx_lo | input | 4 | Lower device bus sample |
| rx_hi | input | 4 | Upper device bus sample |
| rx_byte | output | 8 | Merged receive byte |
| sts_valid | input | 1 | Status bytes present |
| sts_lo | input | 8 | Lower device status |
| sts_hi | input | 8 | Upper device status |
| sts_lo_q | output | 8 | Registered lower status |
| sts_hi_q | output | 8 | Registered upper status |
| busy | output | 1 | Either device busy |
| geo_page_log2 | output | 6 | Host page size, log2 |
| geo_sect_log2 | output | 6 | Host small-erase size, log2 |
| geo_blk_log2 | output | 6 | Host block-erase size, log2 |
| geo_bank_log2 | output | 6 | Host bank size, log2 |
| geo_cap_log2 | output | 6 | Host capacity, log2 |

## Verification
The assertions assume the configuration bits and `tx_data_phase` settle before the clock edge that registers them. They also assume the device status bit 0 means write-in-progress. Across a request, the assertions only compare against the previous cycle's inputs. The stimulus changes every input half a cycle away from the edge. It switches the configuration between transfers and also during random traffic, and it keeps request lengths within the address width so the bank-end arithmetic never wraps.

// File: rtl/qstripe_pkg.sv
package qstripe_pkg;
   typedef enum logic {MODE_SOLO = 1'b0, MODE_PAIR = 1'b1} stripe_mode_e;

   function automatic stripe_mode_e decode_mode(input logic sep_bus, input logic two_mem);
      return (sep_bus && two_mem) ? MODE_PAIR : MODE_SOLO;
   endfunction
endpackage

// File: rtl/qstripe_lane_mux.sv
module qstripe_lane_mux #(
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pair,
   input  logic               tx_data_phase,
   input  logic [LANES-1:0]   tx_nib,
   input  logic [2*LANES-1:0] tx_byte,
   output logic [LANES-1:0]   io_lo_out,
   output logic [LANES-1:0]   io_hi_out,
   output logic               io_oe_hi,
   input  logic [LANES-1:0]   rx_lo,
   input  logic [LANES-1:0]   rx_hi,
   output logic [2*LANES-1:0] rx_byte
);
   localparam int BYTE_W = 2 * LANES;

   logic [LANES-1:0]  even_bits, odd_bits;
   logic [BYTE_W-1:0] woven;
   logic [LANES-1:0]  lo_n, hi_n;
   logic [BYTE_W-1:0] rx_n;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign even_bits[k]   = tx_byte[2*k];
      assign odd_bits[k]    = tx_byte[2*k+1];
      assign woven[2*k]     = rx_lo[k];
      assign woven[2*k+1]   = rx_hi[k];
   end

   always_comb begin
      if (!pair) begin
         lo_n = tx_nib;
         hi_n = '0;
         rx_n = {{LANES{1'b0}}, rx_lo};
      end else begin
         lo_n = tx_data_phase ? even_bits : tx_nib;
         hi_n = tx_data_phase ? odd_bits  : tx_nib;
         rx_n = woven;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_lo_out <= '0;
         io_hi_out <= '0;
         io_oe_hi  <= 1'b0;
         rx_byte   <= '0;
      end else begin
         io_lo_out <= lo_n;
         io_hi_out <= hi_n;
         io_oe_hi  <= pair;
         rx_byte   <= rx_n;
      end
   end

   assert_cmd_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pair && !tx_data_phase) |=> (io_lo_out == io_hi_out) && io_oe_hi);
   assert_odd_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pair && tx_data_phase) |=> (io_hi_out[0] == $past(tx_byte[1])) && (io_lo_out[0] == $past(tx_byte[0])));
   assert_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pair |=> (rx_byte[1] == $past(rx_hi[0])) && (rx_byte[0] == $past(rx_lo[0])));
   assert_solo_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pair |=> !io_oe_hi && (io_hi_out == '0) && (rx_byte[BYTE_W-1:LANES] == '0));
endmodule

// File: rtl/qstripe_addr_map.sv
module qstripe_addr_map #(
   parameter int AW        = 32,
   parameter int BANK_LOG2 = 24,
   parameter int BW        = AW - BANK_LOG2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pair,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic [AW-1:0] req_len,
   output logic          acc_valid,
   output logic          acc_err,
   output logic [AW-1:0] acc_dev_addr,
   output logic [BW-1:0] acc_bank,
   output logic [AW-1:0] acc_len
);
   localparam logic [AW:0]   SOLO_BYTES = {{AW{1'b0}}, 1'b1} << BANK_LOG2;
   localparam logic [AW:0]   PAIR_BYTES = SOLO_BYTES << 1;
   localparam logic [AW-1:0] SOLO_MASK  = SOLO_BYTES[AW-1:0] - 1'b1;
   localparam logic [AW-1:0] PAIR_MASK  = PAIR_BYTES[AW-1:0] - 1'b1;

   if (BANK_LOG2 + 1 >= AW) begin : g_bad_bank
      $error("qstripe_addr_map: BANK_LOG2 must leave room for a doubled bank");
   end
   if (BW != AW - BANK_LOG2) begin : g_bad_bw
      $error("qstripe_addr_map: BW must equal AW - BANK_LOG2");
   end

   logic          odd_n;
   logic [AW-1:0] dev_n, shifted, offs, len_n;
   logic [AW:0]   room;

   always_comb begin
      odd_n   = pair && (req_addr[0] || req_len[0]);
      dev_n   = pair ? (req_addr >> 1) : req_addr;
      shifted = pair ? (req_addr >> (BANK_LOG2 + 1)) : (req_addr >> BANK_LOG2);
      offs    = req_addr & (pair ? PAIR_MASK : SOLO_MASK);
      room    = (pair ? PAIR_BYTES : SOLO_BYTES) - {1'b0, offs};
      if (odd_n)                     len_n = '0;
      else if ({1'b0, req_len} < room) len_n = req_len;
      else                           len_n = room[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid    <= 1'b0;
         acc_err      <= 1'b0;
         acc_dev_addr <= '0;
         acc_bank     <= '0;
         acc_len      <= '0;
      end else begin
         acc_valid <= req_valid;
         if (req_valid) begin
            acc_err      <= odd_n;
            acc_dev_addr <= dev_n;
            acc_bank     <= shifted[BW-1:0];
            acc_len      <= len_n;
         end
      end
   end

   assert_reject_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> (acc_len == '0));
   assert_clip_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_err) |-> (acc_len <= $past(req_len)));
   assert_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> $past(req_valid));
   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(acc_dev_addr) && $stable(acc_len));
endmodule

// File: rtl/qstripe_status.sv
module qstripe_status #(
   parameter int SW      = 8,
   parameter int WIP_BIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pair,
   input  logic          sts_valid,
   input  logic [SW-1:0] sts_lo,
   input  logic [SW-1:0] sts_hi,
   output logic [SW-1:0] sts_lo_q,
   output logic [SW-1:0] sts_hi_q,
   output logic          busy
);
   if (WIP_BIT >= SW) begin : g_bad_wip
      $error("qstripe_status: WIP_BIT outside status width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_lo_q <= '0;
         sts_hi_q <= '0;
         busy     <= 1'b0;
      end else if (sts_valid) begin
         sts_lo_q <= sts_lo;
         sts_hi_q <= pair ? sts_hi : '0;
         busy     <= sts_lo[WIP_BIT] || (pair && sts_hi[WIP_BIT]);
      end
   end

   assert_busy_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sts_lo_q[WIP_BIT] || sts_hi_q[WIP_BIT]));
   assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_valid |=> $stable(busy) && $stable(sts_lo_q));
endmodule

// File: rtl/qstripe_top.sv
module qstripe_top
   import qstripe_pkg::*;
#(
   parameter int AW            = 32,
   parameter int LANES         = 4,
   parameter int BANK_LOG2     = 24,
   parameter int DEV_PAGE_LOG2 = 8,
   parameter int DEV_CAP_LOG2  = 24,
   parameter int SECT_LOG2     = 12,
   parameter int BLK_LOG2      = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_sep_bus,
   input  logic                    cfg_two_mem,
   input  logic                    req_valid,
   input  logic [AW-1:0]           req_addr,
   input  logic [AW-1:0]           req_len,
   output logic                    acc_valid,
   output logic                    acc_err,
   output logic [AW-1:0]           acc_dev_addr,
   output logic [AW-BANK_LOG2-1:0] acc_bank,
   output logic [AW-1:0]           acc_len,
   input  logic                    tx_data_phase,
   input  logic [LANES-1:0]        tx_nib,
   input  logic [2*LANES-1:0]      tx_byte,
   output logic [LANES-1:0]        io_lo_out,
   output logic [LANES-1:0]        io_hi_out,
   output logic                    io_oe_hi,
   input  logic [LANES-1:0]        rx_lo,
   input  logic [LANES-1:0]        rx_hi,
   output logic [2*LANES-1:0]      rx_byte,
   input  logic                    sts_valid,
   input  logic [7:0]              sts_lo,
   input  logic [7:0]              sts_hi,
   output logic [7:0]              sts_lo_q,
   output logic [7:0]              sts_hi_q,
   output logic                    busy,
   output logic [5:0]              geo_page_log2,
   output logic [5:0]              geo_sect_log2,
   output logic [5:0]              geo_blk_log2,
   output logic [5:0]              geo_bank_log2,
   output logic [5:0]              geo_cap_log2
);
   localparam int BW = AW - BANK_LOG2;

   if (DEV_CAP_LOG2 + 1 > AW || DEV_CAP_LOG2 > 62) begin : g_bad_cap
      $error("qstripe_top: paired capacity does not fit the address width");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("qstripe_top: status and nibble paths assume four lanes");
   end

   stripe_mode_e mode;
   logic         pair;
   logic [5:0]   bump;

   assign mode = decode_mode(cfg_sep_bus, cfg_two_mem);
   assign pair = (mode == MODE_PAIR);
   assign bump = {5'b0, pair};

   assign geo_page_log2 = 6'(DEV_PAGE_LOG2) + bump;
   assign geo_sect_log2 = 6'(SECT_LOG2) + bump;
   assign geo_blk_log2  = 6'(BLK_LOG2) + bump;
   assign geo_bank_log2 = 6'(BANK_LOG2) + bump;
   assign geo_cap_log2  = 6'(DEV_CAP_LOG2) + bump;

   qstripe_addr_map #(.AW(AW), .BANK_LOG2(BANK_LOG2), .BW(BW)) u_addr (
      .clk(clk), .rst_n(rst_n), .pair(pair),
      .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
      .acc_valid(acc_valid), .acc_err(acc_err), .acc_dev_addr(acc_dev_addr),
      .acc_bank(acc_bank), .acc_len(acc_len));

   qstripe_lane_mux #(.LANES(LANES)) u_lanes (
      .clk(clk), .rst_n(rst_n), .pair(pair),
      .tx_data_phase(tx_data_phase), .tx_nib(tx_nib), .tx_byte(tx_byte),
      .io_lo_out(io_lo_out), .io_hi_out(io_hi_out), .io_oe_hi(io_oe_hi),
      .rx_lo(rx_lo), .rx_hi(rx_hi), .rx_byte(rx_byte));

   qstripe_status #(.SW(8), .WIP_BIT(0)) u_sts (
      .clk(clk), .rst_n(rst_n), .pair(pair), .sts_valid(sts_valid),
      .sts_lo(sts_lo), .sts_hi(sts_hi),
      .sts_lo_q(sts_lo_q), .sts_hi_q(sts_hi_q), .busy(busy));

   assert_solo_geometry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_sep_bus && cfg_two_mem) |-> (geo_bank_log2 == 6'(BANK_LOG2)));
   assert_pair_geometry_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sep_bus && cfg_two_mem) |-> (geo_page_log2 == 6'(DEV_PAGE_LOG2 + 1)));
endmodule

// File: tb/sim_qstripe_top.sv
module sim_qstripe_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_sep_bus = 0, cfg_two_mem = 0, req_valid = 0, tx_data_phase = 0, sts_valid = 0;
   logic [31:0] req_addr = '0, req_len = '0;
   logic [3:0]  tx_nib = '0, rx_lo = '0, rx_hi = '0;
   logic [7:0]  tx_byte = '0, sts_lo = '0, sts_hi = '0;
   logic acc_valid, acc_err, io_oe_hi, busy;
   logic [31:0] acc_dev_addr, acc_len;
   logic [7:0]  acc_bank, rx_byte, sts_lo_q, sts_hi_q;
   logic [3:0]  io_lo_out, io_hi_out;
   logic [5:0]  geo_page_log2, geo_sect_log2, geo_blk_log2, geo_bank_log2, geo_cap_log2;

   always #(CLK_PERIOD/2) clk = ~clk;

   qstripe_top u0 (.*);

   int n_chk = 0, n_fail = 0;
   logic e_av, e_err, e_oe, e_busy;
   logic [31:0] e_dev, e_len;
   logic [7:0]  e_bank, e_rx, e_slo, e_shi;
   logic [3:0]  e_lo, e_hi;

   task automatic chk(input string rq, input string nm, input logic [63:0] a, input logic [63:0] e);
      n_chk++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", rq, nm, a, e);
      end
   endtask

   task automatic check_all();
      int p;
      p = (cfg_sep_bus && cfg_two_mem) ? 1 : 0;
      chk("R2/R3/R5", "io_lo_out", 64'(io_lo_out), 64'(e_lo));
      chk("R2/R3/R5", "io_hi_out", 64'(io_hi_out), 64'(e_hi));
      chk("R1 R5", "io_oe_hi", 64'(io_oe_hi), 64'(e_oe));
      chk("R4 R5", "rx_byte", 64'(rx_byte), 64'(e_rx));
      chk("R12", "acc_valid", 64'(acc_valid), 64'(e_av));
      chk("R7", "acc_err", 64'(acc_err), 64'(e_err));
      chk("R6", "acc_dev_addr", 64'(acc_dev_addr), 64'(e_dev));
      chk("R8", "acc_bank", 64'(acc_bank), 64'(e_bank));
      chk("R9", "acc_len", 64'(acc_len), 64'(e_len));
      chk("R10", "sts_lo_q", 64'(sts_lo_q), 64'(e_slo));
      chk("R10", "sts_hi_q", 64'(sts_hi_q), 64'(e_shi));
      chk("R10", "busy", 64'(busy), 64'(e_busy));
      chk("R11", "geo_page", 64'(geo_page_log2), 64'(8 + p));
      chk("R11", "geo_sect", 64'(geo_sect_log2), 64'(12 + p));
      chk("R11", "geo_blk", 64'(geo_blk_log2), 64'(15 + p));
      chk("R11", "geo_bank", 64'(geo_bank_log2), 64'(24 + p));
      chk("R11", "geo_cap", 64'(geo_cap_log2), 64'(24 + p));
   endtask

   // reference model for what the outputs show after the coming edge
   task automatic predict();
      bit p;
      longint bsz, room;
      p = cfg_sep_bus && cfg_two_mem;
      if (!rst_n) begin
         {e_av, e_err, e_oe, e_busy} = '0;
         e_dev = 0; e_len = 0; e_bank = 0; e_rx = 0; e_slo = 0; e_shi = 0; e_lo = 0; e_hi = 0;
         return;
      end
      e_oe = p;
      if (!p) begin
         e_lo = tx_nib; e_hi = 0; e_rx = {4'h0, rx_lo};
      end else begin
         if (tx_data_phase) begin
            e_lo = {tx_byte[6], tx_byte[4], tx_byte[2], tx_byte[0]};
            e_hi = {tx_byte[7], tx_byte[5], tx_byte[3], tx_byte[1]};
         end else begin
            e_lo = tx_nib; e_hi = tx_nib;
         end
         for (int k = 0; k < 4; k++) begin
            e_rx[2*k] = rx_lo[k];
            e_rx[2*k+1] = rx_hi[k];
         end
      end
      e_av = req_valid;
      if (req_valid) begin
         bsz   = p ? 64'd33554432 : 64'd16777216;
         e_err = p && (req_addr[0] || req_len[0]);
         e_dev = p ? req_addr / 2 : req_addr;
         e_bank = 8'(longint'(req_addr) / bsz);
         room  = bsz - (longint'(req_addr) % bsz);
         if (e_err) e_len = 0;
         else e_len = (longint'(req_len) < room) ? req_len : 32'(room);
      end
      if (sts_valid) begin
         e_slo = sts_lo;
         e_shi = p ? sts_hi : 8'h00;
         e_busy = sts_lo[0] || (p && sts_hi[0]);
      end
   endtask

   // inputs changed by the caller right after tick returns are seen at the next edge
   task automatic tick();
      @(negedge clk);
      check_all();
   endtask

   task automatic go();
      predict();
      tick();
   endtask

   task automatic idle_req();
      req_valid = 0; sts_valid = 0;
   endtask

   task automatic request(input logic [31:0] a, input logic [31:0] l);
      req_valid = 1; req_addr = a; req_len = l;
      go();
      idle_req();
   endtask

   initial begin
      predict();
      tick(); tick();
      // reset state checked by the two ticks above (R12)
      @(negedge clk); rst_n = 1;
      go();

      // single mode (R1, R5, R6, R8)
      cfg_sep_bus = 1; cfg_two_mem = 0;
      tx_data_phase = 1; tx_nib = 4'hB; tx_byte = 8'hA5; rx_lo = 4'h9; rx_hi = 4'h6; go();
      request(32'h0000_1001, 32'h0000_0003);        // R7: odd allowed in single mode
      request(32'h00FF_FFF8, 32'h0000_0020);        // R9: clipped to 8
      request(32'h0300_0000, 32'h0000_0100);        // R8: bank 3
      go();                                         // R12: fields hold

      // pair mode command phase (R2)
      cfg_two_mem = 1; tx_data_phase = 0; tx_nib = 4'hE; go();
      tx_nib = 4'h3; go();
      // pair data phase (R3) and receive merge (R4)
      tx_data_phase = 1;
      foreach (tx_byte[i]) ;
      tx_byte = 8'hA5; rx_lo = 4'hF; rx_hi = 4'h0; go();
      tx_byte = 8'h3C; rx_lo = 4'h0; rx_hi = 4'hF; go();
      tx_byte = 8'hFF; rx_lo = 4'h5; rx_hi = 4'hA; go();
      tx_byte = 8'h01; rx_lo = 4'h1; rx_hi = 4'h8; go();
      // addressing in pair mode (R6, R7, R8, R9)
      request(32'h0000_2000, 32'h0000_0200);
      request(32'h0000_2001, 32'h0000_0200);        // R7 odd address
      request(32'h0000_2000, 32'h0000_0201);        // R7 odd length
      request(32'h01FF_FFF0, 32'h0000_0040);        // R9 clip to 0x10
      request(32'h0500_0000, 32'h0000_0010);        // R8 bank 2
      request(32'h00FF_FFF8, 32'h0000_0020);        // R9 no clip at device bank
      // status (R10)
      sts_valid = 1; sts_lo = 8'h02; sts_hi = 8'h01; go(); idle_req();
      sts_lo = 8'h01; go();                         // R10 hold without strobe
      cfg_sep_bus = 0;                              // R1 one bit clear
      sts_valid = 1; sts_lo = 8'h00; sts_hi = 8'hFF; go(); idle_req();
      tx_data_phase = 0; tx_nib = 4'h7; go();

      // random traffic across both modes
      for (int i = 0; i < 600; i++) begin
         cfg_sep_bus = ($urandom % 8) != 0;
         cfg_two_mem = ($urandom % 8) != 0;
         tx_data_phase = $urandom; tx_nib = $urandom; tx_byte = $urandom;
         rx_lo = $urandom; rx_hi = $urandom;
         req_valid = $urandom; req_addr = $urandom;
         req_len = ($urandom % 2) ? ($urandom % 4096) : ($urandom % 32'h0400_0000);
         sts_valid = $urandom; sts_lo = $urandom; sts_hi = $urandom;
         go();
      end
      idle_req();
      go();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule